// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block governs the power-down state of a small processor core. A one-cycle sleep strobe from the instruction decoder halts the core and turns the oscillator driver off. The core stays halted until one of two things happens. A reset-type event brings the device back through a full reset. An interrupt source whose enable and flag bits are both set lets execution continue. On entry to sleep the block clears the watchdog, and it clears it again on every wake. It keeps the power-down and timeout status bits that firmware reads to tell why the device restarted.

An interrupt wake does not depend on the global interrupt disable. That bit only selects what happens after the prefetched next instruction has run. If it is set, the core carries on in line. If it is clear, the block raises a one-cycle vector request, and that cycle is also a dummy halt cycle before the fetch from the interrupt vector. Crystal-type oscillator modes hold the core for a start-up count after the wake. The RC mode has no start-up count. If a wake condition is already pending when the strobe arrives, the block skips sleep altogether.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After rst_ni is released, halt_o=0, osc_en_o=1, pd_o=1, to_o=1, and wdt_clr_o, rst_req_o and vec_req_o are all 0.
- R2: While running, a sleep_i pulse with no wake condition pending raises wdt_clr_o in that same cycle. From the next cycle on, halt_o=1, osc_en_o=0, pd_o=0 and to_o=1, and these hold until a wake.
- R3: A wake condition exists only when some bit position i has both int_en_i[i] and int_flag_i[i] set. An enable bit at one position together with a flag bit at a different position does not wake the core, and halt_o stays 1.
- R4: When an interrupt wakes the core with osc_mode_i=2'b00 (RC), halt_o falls in the next cycle. For any other mode, osc_en_o rises in the next cycle and halt_o stays 1 for OST_CYCLES more cycles before it falls.
- R5: wdt_clr_o is 1 in the cycle in which a sleeping core detects a wake condition or a reset event.
- R6: After an interrupt wake, halt_o is 0 for exactly one cycle (the prefetched instruction). If glint_dis_i was 1 at the wake, the core then keeps running with vec_req_o=0. If it was 0, the next cycle has vec_req_o=1 and halt_o=1, and after that the core runs.
- R7: por_i, mclr_i, bor_i, or wdt_to_i while wdt_en_i=1 sets rst_req_o in the same cycle, and the core runs (halt_o=0) from the next cycle. wdt_to_i while wdt_en_i=0 has no effect.
- R8: por_i or bor_i sets pd_o=1 and to_o=1. An enabled watchdog timeout clears to_o and leaves pd_o unchanged. mclr_i leaves both bits unchanged.
- R9: A sleep_i pulse while a wake condition is pending skips sleep. In the next cycle halt_o=0, with pd_o=0 and to_o=1, and osc_en_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep instruction strobe |
| por_i | input | 1 | Power-on reset event |
| mclr_i | input | 1 | External reset event |
| bor_i | input | 1 | Brown-out reset event |
| wdt_to_i | input | 1 | Watchdog timeout |
| wdt_en_i | input | 1 | Watchdog enabled |
| int_en_i | input | N_SRC | Per-source interrupt enables |
| int_flag_i | input | N_SRC | Per-source interrupt flags |
| glint_dis_i | input | 1 | Global interrupt disable |
| osc_mode_i | input | 2 | Oscillator mode, 2'b00 = RC (no start-up count) |
| halt_o | output | 1 | Core halt |
| osc_en_o | output | 1 | Oscillator driver enable |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Timeout status bit |
| rst_req_o | output | 1 | Device reset request |
| vec_req_o | output | 1 | Interrupt vector request |

## Verification
The hardest cases to reach are those where two conditions meet in a single cycle. One is a sleep strobe that lands while an enable and a flag on the same source are already high, which must skip sleep. Another is an enabled watchdog timeout that arrives during sleep. A third is a wake in a crystal mode with vectoring on, where the full start-up count has to pass before the one resume cycle and the dummy vector cycle. The stimulus sets up flags and enables before it pulses the strobe, and it raises the timeout first with the watchdog disabled and only then with it enabled. A behavioural model that follows every clock checks that the timing of each of these paths is exact.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_OST,
    ST_RESUME,
    ST_VECTOR
  } swc_state_e;

  localparam logic [1:0] OSC_RC = 2'b00;
endpackage

// File: rtl/swc_wake_detect.sv
module swc_wake_detect #(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0] int_en_i,
  input  logic [N_SRC-1:0] int_flag_i,
  output logic             wake_o
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = int_en_i[i] & int_flag_i[i];
  end

  assign wake_o = |hit;
endmodule

// File: rtl/swc_ost_counter.sv
module swc_ost_counter #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);

  // R4
  ost_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= LAST));
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int N_SRC      = 8,
  parameter int OST_CYCLES = 1024
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             por_i,
  input  logic             mclr_i,
  input  logic             bor_i,
  input  logic             wdt_to_i,
  input  logic             wdt_en_i,
  input  logic [N_SRC-1:0] int_en_i,
  input  logic [N_SRC-1:0] int_flag_i,
  input  logic             glint_dis_i,
  input  logic [1:0]       osc_mode_i,
  output logic             halt_o,
  output logic             osc_en_o,
  output logic             wdt_clr_o,
  output logic             pd_o,
  output logic             to_o,
  output logic             rst_req_o,
  output logic             vec_req_o
);
  swc_state_e state_q, state_d;
  logic wake_pend, ost_done, ost_clr, wake_go;
  logic rst_evt, hard_evt, wdt_evt, sleep_go;
  logic pd_q, to_q, vec_pend_q;

  swc_wake_detect #(.N_SRC(N_SRC)) i_wake (
    .int_en_i  (int_en_i),
    .int_flag_i(int_flag_i),
    .wake_o    (wake_pend)
  );

  swc_ost_counter #(.OST_CYCLES(OST_CYCLES)) i_ost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (ost_clr),
    .en_i  (state_q == ST_OST),
    .done_o(ost_done)
  );

  assign hard_evt = por_i | bor_i;
  assign wdt_evt  = wdt_to_i & wdt_en_i;
  assign rst_evt  = hard_evt | mclr_i | wdt_evt;
  assign sleep_go = (state_q == ST_RUN) & sleep_i & ~rst_evt;
  assign wake_go  = ~rst_evt & wake_pend &
                    (sleep_go | (state_q == ST_SLEEP));

  always_comb begin
    state_d = state_q;
    ost_clr = 1'b0;
    unique case (state_q)
      ST_RUN:    if (sleep_i) state_d = wake_pend ? ST_RESUME : ST_SLEEP;
      ST_SLEEP:  if (wake_pend) begin
        ost_clr = 1'b1;
        state_d = (osc_mode_i == OSC_RC) ? ST_RESUME : ST_OST;
      end
      ST_OST:    if (ost_done) state_d = ST_RESUME;
      ST_RESUME: state_d = vec_pend_q ? ST_VECTOR : ST_RUN;
      ST_VECTOR: state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
    if (rst_evt) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      pd_q       <= 1'b1;
      to_q       <= 1'b1;
      vec_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hard_evt) begin
        pd_q <= 1'b1;
        to_q <= 1'b1;
      end else if (wdt_evt) begin
        to_q <= 1'b0;
      end else if (sleep_go) begin
        pd_q <= 1'b0;
        to_q <= 1'b1;
      end
      if (rst_evt)      vec_pend_q <= 1'b0;
      else if (wake_go) vec_pend_q <= ~glint_dis_i;
    end
  end

  assign halt_o    = (state_q == ST_SLEEP) | (state_q == ST_OST) |
                     (state_q == ST_VECTOR);
  assign osc_en_o  = (state_q != ST_SLEEP);
  assign vec_req_o = (state_q == ST_VECTOR);
  assign rst_req_o = rst_evt;
  assign wdt_clr_o = sleep_go | ((state_q == ST_SLEEP) & (wake_pend | rst_evt));
  assign pd_o      = pd_q;
  assign to_o      = to_q;

  // R6
  vec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |=> !vec_req_o);
  // R6
  vec_after_resume_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_req_o) |-> $past(!halt_o));
  // R8
  pd_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_o) |-> $past(sleep_i));
  // R8
  to_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(to_o) |-> $past(wdt_to_i && wdt_en_i));
  // R7
  rst_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !halt_o);
endmodule

// File: tb/test_sleep_wake_ctrl.sv
module test_sleep_wake_ctrl;
  localparam int N   = 4;
  localparam int OST = 1024;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic sleep_i = 0, por_i = 0, mclr_i = 0, bor_i = 0, wdt_to_i = 0, wdt_en_i = 0;
  logic [N-1:0] int_en_i = '0, int_flag_i = '0;
  logic glint_dis_i = 1'b1;
  logic [1:0] osc_mode_i = 2'b00;
  logic halt_o, osc_en_o, wdt_clr_o, pd_o, to_o, rst_req_o, vec_req_o;

  sleep_wake_ctrl #(.N_SRC(N), .OST_CYCLES(OST)) i_sleep_wake_ctrl (.*);

  always #5 clk_i = ~clk_i;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  // behavioural model: phase 0 run, 1 asleep, 2 start-up wait, 3 resume, 4 vector
  int m_ph, m_cnt;
  bit m_pd, m_to, m_vec;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_pd = 1; m_to = 1; m_vec = 0;
    end else begin
      bit evp, evw, ev, pend;
      evp  = por_i | bor_i;
      evw  = wdt_to_i & wdt_en_i;
      ev   = evp | evw | mclr_i;
      pend = |(int_en_i & int_flag_i);
      if (evp) begin m_pd = 1; m_to = 1; end
      else if (evw) m_to = 0;
      else if (m_ph == 0 && sleep_i) begin m_pd = 0; m_to = 1; end
      if (ev) begin m_ph = 0; m_vec = 0; end
      else case (m_ph)
        0: if (sleep_i) begin
             if (pend) begin m_ph = 3; m_vec = !glint_dis_i; end
             else m_ph = 1;
           end
        1: if (pend) begin
             m_vec = !glint_dis_i;
             if (osc_mode_i == 2'b00) m_ph = 3;
             else begin m_ph = 2; m_cnt = OST; end
           end
        2: if (m_cnt == 1) m_ph = 3; else m_cnt--;
        3: m_ph = m_vec ? 4 : 0;
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b t=%0t", tag, name, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    cycles++;
    if (rst_ni) begin
      bit ev, pend;
      ev   = por_i | bor_i | mclr_i | (wdt_to_i & wdt_en_i);
      pend = |(int_en_i & int_flag_i);
      chk("halt_o", halt_o, m_ph == 1 || m_ph == 2 || m_ph == 4);
      chk("osc_en_o", osc_en_o, m_ph != 1);
      chk("vec_req_o", vec_req_o, m_ph == 4);
      chk("rst_req_o", rst_req_o, ev);
      chk("wdt_clr_o", wdt_clr_o, (!ev && m_ph == 0 && sleep_i) || (m_ph == 1 && (pend || ev)));
      chk("pd_o", pd_o, m_pd);
      chk("to_o", to_o, m_to);
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic do_sleep();
    sleep_i = 1; step(); sleep_i = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(); s = 0;
  endtask

  initial begin
    step(2); rst_ni = 1;
    tag = "R1"; step(3);
    tag = "R2"; do_sleep(); step(5);
    tag = "R3"; int_en_i = 4'b0001; int_flag_i = 4'b0010; step(6);
    tag = "R6"; glint_dis_i = 1; int_flag_i = 4'b0011; step(); int_flag_i = 0; step(5);
    tag = "R6"; glint_dis_i = 0; do_sleep(); step(3);
    int_flag_i = 4'b0001; step(); int_flag_i = 0; step(6);
    tag = "R4"; osc_mode_i = 2'b01; do_sleep(); step(3);
    int_flag_i = 4'b0001; step(); int_flag_i = 0; step(OST + 6);
    osc_mode_i = 2'b10; glint_dis_i = 1; do_sleep(); step(2);
    int_en_i = 4'b1000; int_flag_i = 4'b1000; step(); int_flag_i = 0; step(20);
    tag = "R5"; mclr_i = 1; step(); mclr_i = 0; step(OST);
    tag = "R7"; osc_mode_i = 2'b00; do_sleep(); step(2);
    wdt_to_i = 1; step(4);
    tag = "R8"; wdt_en_i = 1; step(); wdt_to_i = 0; step(3);
    pulse(por_i); step(2);
    do_sleep(); step(2); pulse(bor_i); step(2);
    do_sleep(); step(2); pulse(mclr_i); step(2);
    tag = "R9"; int_flag_i = 4'b1000; glint_dis_i = 1; do_sleep(); step(4);
    glint_dis_i = 0; do_sleep(); step(4); int_flag_i = 0;
    tag = "R7"; pulse(por_i); step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule